// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Engine

This block is the half-duplex clocked shift mode of a small controller's serial port. It produces a shift clock from the system (oscillator) clock and moves one byte over a single data line. While it transmits it drives the line; while it receives it leaves the line undriven and samples it. A transmit begins when software writes the buffer register. A receive begins when software clears the receive-done flag. Each direction raises its own completion flag at the end of the frame.

Every bit period lasts a fixed number of oscillator cycles. The shift clock is low for the first part of the period and high for the last few cycles. Transmit data change only at period boundaries, which gives a long setup before each rising clock edge and a short hold after it. Receive data are captured at the rising edge. Between frames the clock rests high.

Top module: `ssr_sync_serial`

## Requirements
- R1: After reset, shift_clk is 1, line_oe is 0, tx_done and rx_done are 0, and buf_rdata is 0.
- R2: During a frame, each bit period is 12 clk cycles: shift_clk is 0 for the first 10 and 1 for the last 2. A frame has 8 periods (96 cycles). shift_clk is 1 whenever no frame is running.
- R3: When buf_wr is high in an idle cycle, a transmit frame starts in the next cycle, buf_rdata takes buf_wdata, and line_oe is 1 for the whole frame.
- R4: Transmit bits go out least significant bit first. Bit k appears on line_out for all of period k, so it is valid 10 cycles before the rising shift_clk edge and held 2 cycles after it.
- R5: tx_done becomes 1 in the first cycle after the 96-cycle transmit frame. It stays 1 until tx_flag_clr.
- R6: When rx_flag_clr is high in an idle cycle, a receive frame starts in the next cycle with line_oe at 0, and rx_done is 0 from that cycle on.
- R7: Each received bit is the value of line_in at the clk edge where shift_clk rises, that is, its value in the cycle just before shift_clk goes high. The first bit received is bit 0.
- R8: rx_done becomes 1 in the first cycle after the 96-cycle receive frame. buf_rdata holds the received byte in that same cycle.
- R9: buf_wr and rx_flag_clr during a frame start nothing. Buffer writes are dropped, and the running frame keeps its timing and data.
- R10: If a completion flag's clear arrives in the same cycle that sets it, the flag is set. A clear on its own brings the flag to 0 in the next cycle.
- R11: If buf_wr and rx_flag_clr are both high in one idle cycle, a transmit frame starts, and rx_done is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_wr | input | 1 | Buffer write strobe; starts a transmit when idle |
| buf_wdata | input | 8 | Byte written to the buffer |
| tx_flag_clr | input | 1 | Clear the transmit-done flag |
| rx_flag_clr | input | 1 | Clear the receive-done flag; starts a receive when idle |
| line_in | input | 1 | Serial data line as received |
| buf_rdata | output | 8 | Buffer register contents |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| shift_clk | output | 1 | Shift clock, high when idle |
| line_out | output | 1 | Serial data driven onto the line |
| line_oe | output | 1 | Line drive enable (1 only while transmitting) |

## Verification
Two things can land in the same cycle. A software clear of a completion flag can coincide with the hardware setting that flag in the last cycle of a frame, and a buffer write can coincide with a receive request in one idle cycle. The bench provokes the first by asserting the clear exactly in cycle 95 of a frame, and the second by raising both requests together. The expected result is that the flag reads 1 afterwards, and that the frame which runs is a transmit with line_oe high and the written byte on the line. Randomly placed start requests during frames cover the ignore rule.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_TX   = 2'd1,
    MODE_RX   = 2'd2
  } ssr_mode_e;
endpackage

// File: rtl/ssr_seq.sv
module ssr_seq
  import ssr_pkg::*;
#(
  parameter int DIV  = 12,
  parameter int HOLD = 2,
  parameter int BITS = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_tx,
  input  logic      start_rx,
  output ssr_mode_e mode_o,
  output logic      sclk_o,
  output logic      sample_en_o,
  output logic      shift_en_o,
  output logic      frame_end_o
);
  localparam int PH_W  = (DIV  > 1) ? $clog2(DIV)  : 1;
  localparam int BIT_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int LOW   = DIV - HOLD;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(LOW - 1);
  localparam logic [PH_W-1:0]  PH_LOWN  = PH_W'(LOW);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

  ssr_mode_e         mode_q, mode_n;
  logic [PH_W-1:0]   ph_q, ph_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic              sclk_q, sclk_n;
  logic              busy, period_end, frame_end;

  assign busy       = (mode_q != MODE_IDLE);
  assign period_end = busy && (ph_q == PH_LAST);
  assign frame_end  = period_end && (bit_q == BIT_LAST);

  always_comb begin
    mode_n = mode_q;
    ph_n   = ph_q;
    bit_n  = bit_q;
    if (!busy) begin
      ph_n  = '0;
      bit_n = '0;
      if (start_tx)      mode_n = MODE_TX;
      else if (start_rx) mode_n = MODE_RX;
    end else if (frame_end) begin
      mode_n = MODE_IDLE;
      ph_n   = '0;
      bit_n  = '0;
    end else if (period_end) begin
      ph_n  = '0;
      bit_n = bit_q + 1'b1;
    end else begin
      ph_n = ph_q + 1'b1;
    end
    sclk_n = !((mode_n != MODE_IDLE) && (ph_n < PH_LOWN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      ph_q   <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      mode_q <= mode_n;
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      sclk_q <= sclk_n;
    end
  end

  assign mode_o      = mode_q;
  assign sclk_o      = sclk_q;
  assign sample_en_o = (mode_q == MODE_RX) && (ph_q == PH_RISE);
  assign shift_en_o  = (mode_q == MODE_TX) && period_end;
  assign frame_end_o = frame_end;

  a_r2_idle_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE) |-> sclk_q);
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ph_q <= PH_LAST));
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> $stable(mode_q));
endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath
  import ssr_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ssr_mode_e       mode_i,
  input  logic            load_tx_i,
  input  logic [BITS-1:0] wdata_i,
  input  logic            sample_en_i,
  input  logic            shift_en_i,
  input  logic            rx_commit_i,
  input  logic            line_in_i,
  output logic [BITS-1:0] buf_o,
  output logic            line_out_o,
  output logic            line_oe_o
);
  logic [BITS-1:0] sh_q, sh_n;
  logic [BITS-1:0] buf_q, buf_n;
  logic            sh_en, buf_en;

  always_comb begin
    sh_en  = 1'b0;
    sh_n   = sh_q;
    buf_en = 1'b0;
    buf_n  = buf_q;
    if (load_tx_i) begin
      sh_en  = 1'b1;
      sh_n   = wdata_i;
      buf_en = 1'b1;
      buf_n  = wdata_i;
    end else if (sample_en_i) begin
      sh_en = 1'b1;
      sh_n  = {line_in_i, sh_q[BITS-1:1]};
    end else if (shift_en_i) begin
      sh_en = 1'b1;
      sh_n  = {1'b1, sh_q[BITS-1:1]};
    end
    if (rx_commit_i) begin
      buf_en = 1'b1;
      buf_n  = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      buf_q <= '0;
    end else begin
      if (sh_en)  sh_q  <= sh_n;
      if (buf_en) buf_q <= buf_n;
    end
  end

  assign buf_o      = buf_q;
  assign line_oe_o  = (mode_i == MODE_TX);
  assign line_out_o = (mode_i == MODE_TX) ? sh_q[0] : 1'b1;

  a_r4_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_TX && !shift_en_i) |=> ((mode_i != MODE_TX) || $stable(line_out_o)));
  a_r6_rx_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_RX) |-> !line_oe_o);
endmodule

// File: rtl/ssr_flag.sv
module ssr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_n;

  always_comb begin
    flag_n = flag_q;
    if (set_i)      flag_n = 1'b1;
    else if (clr_i) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_n;
  end

  assign flag_o = flag_q;

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/ssr_sync_serial.sv
module ssr_sync_serial
  import ssr_pkg::*;
#(
  parameter int DIV  = 12,
  parameter int HOLD = 2,
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            buf_wr,
  input  logic [BITS-1:0] buf_wdata,
  input  logic            tx_flag_clr,
  input  logic            rx_flag_clr,
  input  logic            line_in,
  output logic [BITS-1:0] buf_rdata,
  output logic            tx_done,
  output logic            rx_done,
  output logic            shift_clk,
  output logic            line_out,
  output logic            line_oe
);
  localparam int NFLAG = 2;

  ssr_mode_e  mode;
  logic       idle, start_tx, start_rx;
  logic       sample_en, shift_en, frame_end;
  logic [NFLAG-1:0] f_set, f_clr, f_val;

  assign idle     = (mode == MODE_IDLE);
  assign start_tx = idle && buf_wr;
  assign start_rx = idle && rx_flag_clr && !buf_wr;

  ssr_seq #(.DIV(DIV), .HOLD(HOLD), .BITS(BITS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_tx    (start_tx),
    .start_rx    (start_rx),
    .mode_o      (mode),
    .sclk_o      (shift_clk),
    .sample_en_o (sample_en),
    .shift_en_o  (shift_en),
    .frame_end_o (frame_end)
  );

  ssr_datapath #(.BITS(BITS)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .load_tx_i   (start_tx),
    .wdata_i     (buf_wdata),
    .sample_en_i (sample_en),
    .shift_en_i  (shift_en),
    .rx_commit_i (frame_end && (mode == MODE_RX)),
    .line_in_i   (line_in),
    .buf_o       (buf_rdata),
    .line_out_o  (line_out),
    .line_oe_o   (line_oe)
  );

  assign f_set[0] = frame_end && (mode == MODE_TX);
  assign f_clr[0] = tx_flag_clr;
  assign f_set[1] = frame_end && (mode == MODE_RX);
  assign f_clr[1] = rx_flag_clr;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ssr_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .flag_o (f_val[g])
    );
  end

  assign tx_done = f_val[0];
  assign rx_done = f_val[1];

  a_r9_buf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && buf_wr && !frame_end) |=> $stable(buf_rdata));
  a_r8_rx_done_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> (mode == MODE_IDLE));
  a_r5_tx_done_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (mode == MODE_IDLE));
endmodule

// File: tb/tb_ssr_sync_serial.sv
module tb_ssr_sync_serial;
  localparam int PER   = 12;
  localparam int LOWC  = 10;
  localparam int FRAME = 96;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       buf_wr, tx_flag_clr, rx_flag_clr, line_in;
  logic [7:0] buf_wdata, buf_rdata;
  logic       tx_done, rx_done, shift_clk, line_out, line_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bit exp_tx = 0;
  bit exp_rx = 0;

  always #10 clk = ~clk;

  ssr_sync_serial dut (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr), .line_in(line_in),
    .buf_rdata(buf_rdata), .tx_done(tx_done), .rx_done(rx_done),
    .shift_clk(shift_clk), .line_out(line_out), .line_oe(line_oe)
  );

  function automatic bit exp_sclk(input int t);
    return (t % PER) >= LOWC;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Entered and left at a negedge in an idle cycle.
  task automatic frame(input bit is_tx, input logic [7:0] val, input bit intrude,
                       input bit clr_end, input bit both_req);
    logic [7:0] buf_before;
    buf_before = buf_rdata;
    if (is_tx) begin
      buf_wr = 1; buf_wdata = val;
      if (both_req) begin rx_flag_clr = 1; exp_rx = 0; end
    end else begin
      rx_flag_clr = 1; exp_rx = 0;
    end
    @(negedge clk);
    buf_wr = 0; rx_flag_clr = 0; buf_wdata = ~val;
    for (int t = 0; t < FRAME; t++) begin
      int b;
      b = t / PER;
      chk("R2 shift_clk", 32'(shift_clk), 32'(exp_sclk(t)));
      if (is_tx) begin
        chk(both_req ? "R11 tx wins, line driven" : "R3 line_oe", 32'(line_oe), 32'd1);
        chk("R4 line_out bit", 32'(line_out), 32'(val[b]));
        if (t == 0) chk("R3 buffer loaded", 32'(buf_rdata), 32'(val));
      end else begin
        chk("R6 line_oe", 32'(line_oe), 32'd0);
        if (t == 0) chk("R6 rx_done cleared", 32'(rx_done), 32'd0);
        line_in = ((t % PER) == LOWC - 1) ? val[b] : ~val[b];
      end
      buf_wr = 0; rx_flag_clr = 0; tx_flag_clr = 0;
      if (intrude && t == 40) begin
        buf_wr = 1; buf_wdata = ~val; rx_flag_clr = 1; exp_rx = is_tx ? 0 : exp_rx;
      end
      if (clr_end && t == FRAME - 1) begin
        if (is_tx) tx_flag_clr = 1; else rx_flag_clr = 1;
      end
      @(negedge clk);
    end
    buf_wr = 0; rx_flag_clr = 0; tx_flag_clr = 0; line_in = 1;
    if (is_tx) exp_tx = 1; else exp_rx = 1;
    chk("R2 idle clock high", 32'(shift_clk), 32'd1);
    chk("R2 line released", 32'(line_oe), 32'd0);
    chk(clr_end ? "R10 set wins tx" : "R5 tx_done", 32'(tx_done), 32'(exp_tx));
    chk(clr_end ? "R10 set wins rx" : "R8 rx_done", 32'(rx_done), 32'(exp_rx));
    if (is_tx) chk(intrude ? "R9 buffer write ignored" : "R3 buffer", 32'(buf_rdata), 32'(val));
    else       chk(intrude ? "R9 rx byte kept" : "R8 rx byte R7", 32'(buf_rdata), 32'(val));
    if (is_tx) begin
      tx_flag_clr = 1;
      @(negedge clk);
      tx_flag_clr = 0; exp_tx = 0;
      chk("R10 clear drops tx_done", 32'(tx_done), 32'd0);
      chk("R2 still idle", 32'(shift_clk), 32'd1);
    end
    if (buf_before === 8'hxx) chk("R1 buffer", 32'd0, 32'd1);
  endtask

  initial begin
    #(100000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; buf_wr = 0; buf_wdata = 0; tx_flag_clr = 0; rx_flag_clr = 0; line_in = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 shift_clk", 32'(shift_clk), 32'd1);
    chk("R1 line_oe", 32'(line_oe), 32'd0);
    chk("R1 tx_done", 32'(tx_done), 32'd0);
    chk("R1 rx_done", 32'(rx_done), 32'd0);
    chk("R1 buf_rdata", 32'(buf_rdata), 32'd0);

    frame(1, 8'hA5, 0, 0, 0);
    frame(0, 8'h3C, 0, 0, 0);
    frame(1, 8'h01, 1, 0, 0);
    frame(0, 8'h80, 1, 0, 0);
    frame(1, 8'hFF, 0, 1, 0);
    frame(0, 8'h00, 0, 1, 0);
    frame(1, 8'h5A, 0, 0, 1);
    for (int i = 0; i < 30; i++) begin
      logic [31:0] r;
      r = $urandom();
      frame(r[0], r[15:8], r[1], r[2], r[3] & r[0]);
    end
    summary();
  end
endmodule